// File: doc/BRIEF.md
# Transmit Descriptor Poll Scheduler

This block tells a DMA buffer manager when to fetch and inspect the next transmit descriptor. A periodic tick from a timer normally starts a poll. A host demand strobe also starts one, and so does the end of a stretch of receive activity. The block turns these events into a single-cycle poll request. It then holds off any further request until the descriptor fetch logic returns a one-cycle done pulse.

A configuration bit switches automatic polling off. When it is set, only a host demand starts a poll. No poll is raised while the transmitter is off or while the stop input is high, and events that arrive in those conditions are dropped. A poll that is due waits while receive activity is in progress.

Events that arrive while a poll is pending or in flight are not queued. They merge into a single outstanding follow-up poll. A hard reset (asynchronous, active low) or a soft reset (synchronous) returns the block to idle and re-enables automatic polling.

Top module: `txpoll_sched`

## Requirements
- R1: After hard reset, `poll_req_o` is 0, nothing is pending and automatic polling is enabled.
- R2: With automatic polling enabled, the transmitter on, stop low and receive idle, a `tick_i` pulse sampled on edge n makes `poll_req_o` high for exactly the cycle that follows edge n+1.
- R3: While the disable bit is 1, `tick_i` and `rx_done_i` pulses start no poll.
- R4: A `demand_i` pulse starts a poll with the same timing as R2, whatever the value of the disable bit.
- R5: No poll is raised while `tx_on_i` is 0. A demand or tick seen while it is 0 is discarded and does not lead to a poll after `tx_on_i` returns to 1.
- R6: A pending poll is held while `rx_busy_i` is 1. It is issued, with `poll_req_o` high, in the cycle after the first edge at which `rx_busy_i` is sampled 0.
- R7: With automatic polling enabled, an `rx_done_i` pulse starts a poll.
- R8: `poll_req_o` is high for one cycle per poll. No new request is raised until `poll_done_i` has been sampled high after the previous request.
- R9: Any number of events that arrive while a poll is pending or in flight produce at most one further poll once that poll completes.
- R10: While `stop_i` is 1, no poll is raised and pending events are discarded. The disable bit keeps its value across stop.
- R11: A soft reset pulse clears the pending event, the in-flight state and the disable bit.
- R12: A write with `cfg_we_i`=1 loads `cfg_dis_i` into the disable bit, and the new value governs events from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst_i | input | 1 | Soft reset, synchronous, active high |
| tick_i | input | 1 | Periodic poll tick |
| demand_i | input | 1 | Host transmit-demand strobe |
| rx_done_i | input | 1 | Pulse at the end of receive activity |
| rx_busy_i | input | 1 | Receive activity in progress |
| tx_on_i | input | 1 | Transmitter enabled |
| stop_i | input | 1 | Stop bit |
| cfg_we_i | input | 1 | Write strobe for the disable bit |
| cfg_dis_i | input | 1 | Value written to the disable bit (1 = automatic polling off) |
| poll_done_i | input | 1 | Descriptor fetch finished |
| poll_req_o | output | 1 | One-cycle descriptor poll request |

## Verification
The main poll path is driven by ticks, by demands and by receive-done pulses, each with automatic polling both enabled and disabled. This separates the two trigger classes and the disable bit's reach over each. The same triggers are then applied with the transmitter off, with stop high and with receive busy. These runs tell a discarded event apart from one that is only deferred, because polls are counted after the blocking condition is released. Bursts of ticks and demands are sent during a long fetch latency to show that they merge into one follow-up poll. A reference model, compared on every clock, also pins down the exact issue cycle.

// File: rtl/txp_pkg.sv
package txp_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } txp_st_e;

    typedef struct packed {
        logic dis;
    } txp_cfg_s;

    typedef struct packed {
        logic pend;
    } txp_trig_s;

    typedef struct packed {
        txp_st_e st;
        logic    req;
    } txp_issue_s;

endpackage

// File: rtl/txp_cfg.sv
module txp_cfg
    import txp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic stop_i,
    input  logic wr_en_i,
    input  logic wr_dis_i,
    output logic dis_o
);

    txp_cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (soft_rst_i) begin
            cfg_d.dis = 1'b0;
        end else if (wr_en_i) begin
            cfg_d.dis = wr_dis_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dis_o = cfg_q.dis;

    // R10
    dis_stop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (stop_i && !wr_en_i) |=> $stable(cfg_q.dis));

    // R12
    dis_write_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        wr_en_i |=> (cfg_q.dis == $past(wr_dis_i)));

endmodule

// File: rtl/txp_trig.sv
module txp_trig
    import txp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic tick_i,
    input  logic demand_i,
    input  logic rx_done_i,
    input  logic tx_on_i,
    input  logic stop_i,
    input  logic dis_i,
    input  logic issue_i,
    output logic pend_o
);

    txp_trig_s trig_d, trig_q;
    logic      allowed;
    logic      auto_ev;
    logic      any_ev;

    always_comb begin
        allowed = tx_on_i && !stop_i;
        auto_ev = !dis_i && (tick_i || rx_done_i);
        any_ev  = allowed && (demand_i || auto_ev);
        trig_d  = trig_q;
        if (soft_rst_i || !allowed) begin
            trig_d.pend = 1'b0;
        end else begin
            trig_d.pend = (trig_q.pend && !issue_i) || any_ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else begin
            trig_q <= trig_d;
        end
    end

    assign pend_o = trig_q.pend;

    // R5
    pend_txoff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        !tx_on_i |=> !trig_q.pend);

    // R3
    pend_dis_auto_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (!trig_q.pend && dis_i && !demand_i) |=> !trig_q.pend);

    // R9
    pend_merge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        (trig_q.pend && !issue_i && tx_on_i && !stop_i) |=> trig_q.pend);

endmodule

// File: rtl/txp_issue.sv
module txp_issue
    import txp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic pend_i,
    input  logic rx_busy_i,
    input  logic tx_on_i,
    input  logic stop_i,
    input  logic done_i,
    output logic issue_o,
    output logic req_o
);

    txp_issue_s iss_d, iss_q;
    logic       go;

    always_comb begin
        go    = (iss_q.st == ST_IDLE) && pend_i && !rx_busy_i && tx_on_i && !stop_i;
        iss_d = iss_q;
        iss_d.req = 1'b0;
        if (soft_rst_i) begin
            iss_d.st = ST_IDLE;
        end else begin
            unique case (iss_q.st)
                ST_IDLE: begin
                    if (go) begin
                        iss_d.st  = ST_WAIT;
                        iss_d.req = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (done_i) begin
                        iss_d.st = ST_IDLE;
                    end
                end
                default: iss_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_q <= '{st: ST_IDLE, req: 1'b0};
        end else begin
            iss_q <= iss_d;
        end
    end

    assign issue_o = go && !soft_rst_i;
    assign req_o   = iss_q.req;

    // R5
    req_txoff_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        !tx_on_i |=> !iss_q.req);

    // R6
    req_rxbusy_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        rx_busy_i |=> !iss_q.req);

    // R10
    req_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        stop_i |=> !iss_q.req);

    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        iss_q.req |=> !iss_q.req);

    // R8
    req_wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_i)
        ((iss_q.st == ST_WAIT) && !done_i) |=> !iss_q.req);

endmodule

// File: rtl/txpoll_sched.sv
module txpoll_sched
    import txp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic tick_i,
    input  logic demand_i,
    input  logic rx_done_i,
    input  logic rx_busy_i,
    input  logic tx_on_i,
    input  logic stop_i,
    input  logic cfg_we_i,
    input  logic cfg_dis_i,
    input  logic poll_done_i,
    output logic poll_req_o
);

    logic dis;
    logic pend;
    logic issue;

    txp_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .stop_i     (stop_i),
        .wr_en_i    (cfg_we_i),
        .wr_dis_i   (cfg_dis_i),
        .dis_o      (dis)
    );

    txp_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .tick_i     (tick_i),
        .demand_i   (demand_i),
        .rx_done_i  (rx_done_i),
        .tx_on_i    (tx_on_i),
        .stop_i     (stop_i),
        .dis_i      (dis),
        .issue_i    (issue),
        .pend_o     (pend)
    );

    txp_issue u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .pend_i     (pend),
        .rx_busy_i  (rx_busy_i),
        .tx_on_i    (tx_on_i),
        .stop_i     (stop_i),
        .done_i     (poll_done_i),
        .issue_o    (issue),
        .req_o      (poll_req_o)
    );

endmodule

// File: tb/test_txpoll_sched.sv
`timescale 1ns/1ps
module test_txpoll_sched;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic tick = 1'b0, demand = 1'b0, rx_done = 1'b0, rx_busy = 1'b0;
    logic tx_on = 1'b1, stop = 1'b0, we = 1'b0, din = 1'b0;
    logic done = 1'b0;
    logic req;

    int total = 0;
    int bad = 0;
    int npolls = 0;
    int resp_lat = 2;
    int resp_cnt = 0;
    bit finished = 1'b0;
    string cur = "R1";

    // behavioural reference state
    bit m_dis = 0, m_pend = 0, m_busy = 0, m_req = 0;

    always #2.5 clk = ~clk;

    txpoll_sched i_txpoll_sched (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .tick_i(tick),
        .demand_i(demand), .rx_done_i(rx_done), .rx_busy_i(rx_busy),
        .tx_on_i(tx_on), .stop_i(stop), .cfg_we_i(we), .cfg_dis_i(din),
        .poll_done_i(done), .poll_req_o(req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: advanced at each rising edge from sampled inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || soft_rst) begin
            m_dis = 0; m_pend = 0; m_busy = 0; m_req = 0;
        end else begin
            bit ok_tx, fire, ev;
            ok_tx = tx_on && !stop;
            fire  = !m_busy && m_pend && !rx_busy && ok_tx;
            ev    = ok_tx && (demand || (!m_dis && (tick || rx_done)));
            m_req = fire;
            if (fire) m_busy = 1;
            else if (m_busy && done) m_busy = 0;
            m_pend = ok_tx ? ((m_pend && !fire) || ev) : 0;
            if (we) m_dis = din;
        end
    end

    // per-cycle comparison, responder and poll counter
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(req == m_req, cur, req, m_req);
            if (req) npolls++;
        end
        done <= 1'b0;
        if (req) resp_cnt = resp_lat;
        else if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) done <= 1'b1;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; cyc(1); s = 1'b0;
    endtask

    task automatic wr_dis(input bit v);
        din = v; we = 1'b1; cyc(1); we = 1'b0;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        cur = "R1";
        check(req == 1'b0, "R1 req after reset", req, 0);
        npolls = 0; pulse(tick); cyc(10);
        check(npolls == 1, "R1 auto polling enabled after reset", npolls, 1);

        // R2 exact timing of a tick-started poll
        cur = "R2";
        tick = 1'b1; cyc(1); tick = 1'b0;
        check(req == 1'b0, "R2 no req one cycle after tick", req, 0);
        cyc(1);
        check(req == 1'b1, "R2 req two edges after tick", req, 1);
        cyc(1);
        check(req == 1'b0, "R2 req lasts one cycle", req, 0);
        cyc(10);

        // R3 / R12 disable suppresses tick and rx_done
        cur = "R3";
        wr_dis(1'b1);
        npolls = 0;
        pulse(tick); cyc(2); pulse(rx_done); cyc(2); pulse(tick); cyc(10);
        check(npolls == 0, "R3 no auto poll when disabled", npolls, 0);
        cur = "R12";
        din = 1'b0; we = 1'b1; tick = 1'b1; cyc(1); we = 1'b0; tick = 1'b0; cyc(10);
        check(npolls == 0, "R12 old disable value governs write cycle", npolls, 0);
        wr_dis(1'b1);

        // R4 demand works while disabled
        cur = "R4";
        npolls = 0;
        demand = 1'b1; cyc(1); demand = 1'b0; cyc(1);
        check(req == 1'b1, "R4 demand req timing", req, 1);
        cyc(10);
        check(npolls == 1, "R4 one poll from demand", npolls, 1);

        // R5 transmitter off drops events
        cur = "R5";
        wr_dis(1'b0);
        npolls = 0;
        tx_on = 1'b0;
        pulse(demand); cyc(2); pulse(tick); cyc(5);
        tx_on = 1'b1; cyc(10);
        check(npolls == 0, "R5 events with tx off discarded", npolls, 0);

        // R6 receive busy defers
        cur = "R6";
        npolls = 0;
        rx_busy = 1'b1;
        pulse(demand); cyc(8);
        check(npolls == 0, "R6 held while rx busy", npolls, 0);
        rx_busy = 1'b0; cyc(1);
        check(req == 1'b1, "R6 issued after rx idle", req, 1);
        cyc(10);

        // R7 receive done triggers poll
        cur = "R7";
        npolls = 0;
        pulse(rx_done); cyc(10);
        check(npolls == 1, "R7 rx_done starts poll", npolls, 1);

        // R8 / R9 long latency, bursts merge
        cur = "R9";
        resp_lat = 12;
        npolls = 0;
        pulse(demand); cyc(2);
        pulse(tick); pulse(demand); cyc(1); pulse(tick); pulse(rx_done); cyc(30);
        check(npolls == 2, "R9 burst merges into one follow-up", npolls, 2);
        cur = "R8";
        npolls = 0;
        pulse(demand); cyc(3); pulse(demand); cyc(6);
        check(npolls == 1, "R8 no second req before done", npolls, 1);
        cyc(30);
        check(npolls == 2, "R8 follow-up after done", npolls, 2);
        resp_lat = 2;

        // R10 stop blocks, drops, keeps disable bit
        cur = "R10";
        npolls = 0;
        stop = 1'b1;
        pulse(demand); pulse(tick); cyc(4);
        wr_dis(1'b1); cyc(2);
        stop = 1'b0; cyc(10);
        check(npolls == 0, "R10 no poll under stop", npolls, 0);
        stop = 1'b1; cyc(3); stop = 1'b0;
        pulse(tick); cyc(10);
        check(npolls == 0, "R10 disable bit kept across stop", npolls, 0);

        // R11 soft reset clears disable and pending
        cur = "R11";
        rx_busy = 1'b1; pulse(demand); cyc(2);
        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
        rx_busy = 1'b0; cyc(10);
        check(npolls == 0, "R11 pending cleared by soft reset", npolls, 0);
        pulse(tick); cyc(10);
        check(npolls == 1, "R11 disable cleared by soft reset", npolls, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule